// File: doc/BRIEF.md
# Receive Link Status Poller with Automatic Retry

This block watches the receive side of a multi-rate serial Ethernet PCS. Each poll tick starts a status refresh. A refresh strobe goes high for a fixed settle window and then low for a second window of the same length. Only after both windows does the block sample the raw link bit. If the link is down, the block drops its reported link and speed and asks the configuration sequencer to run a full reconfiguration. It keeps asking on every poll until the link comes up. A line-side link-up event also triggers a reconfiguration, which restores receive signal quality.

When the link is up and auto-negotiation is on, the block refreshes the partner ability word with a separate latch strobe that uses the same two settle windows. It then captures the 16-bit word. Speed comes from word bits [11:9] and duplex from bit 12. When auto-negotiation is off, speed comes from a compile-time table indexed by the programmed speed code and rate-adaptation code, and duplex is reported as full. Speed is given in Mb/s together with a separate valid flag, so an unknown speed is kept distinct from every real speed.

The state machine has eight states:

| State | Activity |
|---|---|
| IDLE | waiting for a poll tick or a pending event |
| REFRESH_HI | refresh strobe high |
| REFRESH_LO | refresh settle gap |
| SAMPLE | link bit decision |
| LATCH_HI | latch strobe high |
| LATCH_LO | latch settle gap |
| CAPTURE | partner word taken |
| RECONF | reconfiguration request held until acknowledged |

Its transitions are as follows:

| From | Condition | To |
|---|---|---|
| IDLE | a line event is pending or arrives | RECONF (a poll tick in the same cycle is dropped) |
| IDLE | a poll tick arrives | REFRESH_HI |
| REFRESH_HI | window expires | REFRESH_LO |
| REFRESH_LO | window expires | SAMPLE |
| SAMPLE | link down | RECONF |
| SAMPLE | link up, auto-negotiation on | LATCH_HI |
| SAMPLE | link up, auto-negotiation off | IDLE |
| LATCH_HI | window expires | LATCH_LO |
| LATCH_LO | window expires | CAPTURE |
| CAPTURE | always | IDLE |
| RECONF | acknowledge | IDLE |

Top module: `link_watch`

## Requirements
- R1: After reset, link_up, speed_valid, full_duplex, status_refresh, latch_strobe and reconfig_req are all 0.
- R2: Each poll holds status_refresh high for exactly SETTLE_CYC cycles. The link bit is then sampled after SETTLE_CYC further cycles with the strobe low, and outputs change on the following edge.
- R3: A poll that samples rx_link_raw = 0 clears link_up, speed_valid and full_duplex, and raises reconfig_req. The request is held until reconfig_ack and is raised again by every later poll that finds the link down.
- R4: With the link up and an_enable = 1, latch_strobe goes high for SETTLE_CYC cycles and then low for SETTLE_CYC cycles. The block then copies partner_word to partner_ability and decodes it. Duplex is bit 12. Speed is bits [11:9]: 0=10, 1=100, 2=1000, 3=10000, 4=2500, 5=5000 Mb/s. Codes 6 and 7 are unknown.
- R5: With the link up and an_enable = 0, the base speed is 10000, 5000 or 2500 Mb/s for spd_code 0, 1 and 3. Any other spd_code gives speed_valid = 0.
- R6: In fixed mode the base speed is divided according to adapt_code: 0→1, 1→2, 2→4, 3→10, 4→100, 5→5, 6→50. adapt_code 7 gives speed_valid = 0.
- R7: A fixed-mode result with a known speed reports full_duplex = 1. An unknown fixed speed reports full_duplex = 0 with link_up = 1.
- R8: A line_up_evt pulse causes reconfig_req. In IDLE the request follows on the next edge. During a poll the event is held and served when the poll returns to IDLE.
- R9: A poll tick that arrives while a poll or reconfiguration is in progress is dropped. Reported outputs hold their values until the next sample.
- R10: At most one of status_refresh, latch_strobe and reconfig_req is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| poll_tick | input | 1 | one-cycle request to poll link status |
| line_up_evt | input | 1 | one-cycle line-side link-up event |
| rx_link_raw | input | 1 | raw receive link bit from the PCS |
| an_enable | input | 1 | auto-negotiation mode programmed |
| spd_code | input | 3 | programmed serial speed code |
| adapt_code | input | 3 | programmed rate-adaptation code |
| partner_word | input | WORD_W | partner ability word from the PCS |
| reconfig_ack | input | 1 | sequencer accepted the reconfiguration |
| status_refresh | output | 1 | status update strobe toward the PCS |
| latch_strobe | output | 1 | partner word latch strobe toward the PCS |
| reconfig_req | output | 1 | full reconfiguration request |
| link_up | output | 1 | reported link state |
| speed_valid | output | 1 | speed_mbps holds a known speed |
| speed_mbps | output | 14 | reported speed in Mb/s |
| full_duplex | output | 1 | reported duplex |
| partner_ability | output | WORD_W | last captured partner word |

## Verification
The assertions assume that reconfig_ack is raised only while reconfig_req is high. They also assume that the sampled inputs (rx_link_raw, an_enable, codes and partner_word) are steady from the start of a poll until its decision point. The stimulus meets these assumptions by changing those inputs only while the block is idle, before the next tick. The one exception is the hold test, where rx_link_raw is changed mid-poll on purpose. The stimulus pulses the acknowledge only after it has observed the request.

// File: rtl/link_watch_pkg.sv
`timescale 1ns/1ps
package link_watch_pkg;
    localparam int MBPS_W = 14;
    localparam int CODE_W = 3;
    localparam int SEL_W  = 2 * CODE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REFRESH_HI,
        ST_REFRESH_LO,
        ST_SAMPLE,
        ST_LATCH_HI,
        ST_LATCH_LO,
        ST_CAPTURE,
        ST_RECONF
    } mon_state_t;

    typedef struct packed {
        logic              valid;
        logic [MBPS_W-1:0] mbps;
    } rate_t;

    // Speed for fixed mode: base selected by upper code, divider by lower code.
    function automatic rate_t fixed_rate(input logic [SEL_W-1:0] sel);
        int    base;
        int    div;
        rate_t r;
        case (sel[SEL_W-1:CODE_W])
            3'd0:    base = 10000;
            3'd1:    base = 5000;
            3'd3:    base = 2500;
            default: base = 0;
        endcase
        case (sel[CODE_W-1:0])
            3'd0:    div = 1;
            3'd1:    div = 2;
            3'd2:    div = 4;
            3'd3:    div = 10;
            3'd4:    div = 100;
            3'd5:    div = 5;
            3'd6:    div = 50;
            default: div = 0;
        endcase
        if (base == 0 || div == 0) begin
            r = '0;
        end else begin
            r.valid = 1'b1;
            r.mbps  = MBPS_W'(base / div);
        end
        return r;
    endfunction

    // Speed carried in a negotiated partner word.
    function automatic rate_t an_rate(input logic [CODE_W-1:0] code);
        rate_t r;
        r.valid = 1'b1;
        case (code)
            3'd0:    r.mbps = MBPS_W'(10);
            3'd1:    r.mbps = MBPS_W'(100);
            3'd2:    r.mbps = MBPS_W'(1000);
            3'd3:    r.mbps = MBPS_W'(10000);
            3'd4:    r.mbps = MBPS_W'(2500);
            3'd5:    r.mbps = MBPS_W'(5000);
            default: r      = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/settle_timer.sv
`timescale 1ns/1ps
module settle_timer #(
    parameter int SETTLE_CYC = 204
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic expired
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (run)   cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/fixed_rate_lut.sv
`timescale 1ns/1ps
module fixed_rate_lut
    import link_watch_pkg::*;
(
    input  logic [CODE_W-1:0] base_code,
    input  logic [CODE_W-1:0] div_code,
    output rate_t             rate
);
    localparam int ENTRIES = 1 << SEL_W;

    rate_t table_w [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        localparam rate_t ENT = fixed_rate(SEL_W'(g));
        assign table_w[g] = ENT;
    end

    assign rate = table_w[{base_code, div_code}];
endmodule

// File: rtl/an_word_decode.sv
`timescale 1ns/1ps
module an_word_decode
    import link_watch_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word,
    output rate_t             rate,
    output logic              duplex
);
    localparam int SPD_LSB = 9;
    localparam int DUP_BIT = 12;

    assign rate   = an_rate(word[SPD_LSB +: CODE_W]);
    assign duplex = word[DUP_BIT];
endmodule

// File: rtl/link_watch.sv
`timescale 1ns/1ps
module link_watch
    import link_watch_pkg::*;
#(
    parameter int SETTLE_CYC = 204,
    parameter int WORD_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_tick,
    input  logic              line_up_evt,
    input  logic              rx_link_raw,
    input  logic              an_enable,
    input  logic [2:0]        spd_code,
    input  logic [2:0]        adapt_code,
    input  logic [WORD_W-1:0] partner_word,
    input  logic              reconfig_ack,
    output logic              status_refresh,
    output logic              latch_strobe,
    output logic              reconfig_req,
    output logic              link_up,
    output logic              speed_valid,
    output logic [13:0]       speed_mbps,
    output logic              full_duplex,
    output logic [WORD_W-1:0] partner_ability
);
    mon_state_t state_q, state_d;
    logic       evt_pend_q;
    logic       timed, expired;
    rate_t      fix_rate, neg_rate;
    logic       neg_duplex;

    assign timed = (state_q == ST_REFRESH_HI) || (state_q == ST_REFRESH_LO) ||
                   (state_q == ST_LATCH_HI)   || (state_q == ST_LATCH_LO);

    settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timed),
        .clr     (expired || !timed),
        .expired (expired)
    );

    fixed_rate_lut u_lut (
        .base_code (spd_code),
        .div_code  (adapt_code),
        .rate      (fix_rate)
    );

    an_word_decode #(.WORD_W(WORD_W)) u_dec (
        .word   (partner_word),
        .rate   (neg_rate),
        .duplex (neg_duplex)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (line_up_evt || evt_pend_q) state_d = ST_RECONF;
                else if (poll_tick)            state_d = ST_REFRESH_HI;
            end
            ST_REFRESH_HI: if (expired) state_d = ST_REFRESH_LO;
            ST_REFRESH_LO: if (expired) state_d = ST_SAMPLE;
            ST_SAMPLE: begin
                if (!rx_link_raw)   state_d = ST_RECONF;
                else if (an_enable) state_d = ST_LATCH_HI;
                else                state_d = ST_IDLE;
            end
            ST_LATCH_HI:   if (expired) state_d = ST_LATCH_LO;
            ST_LATCH_LO:   if (expired) state_d = ST_CAPTURE;
            ST_CAPTURE:    state_d = ST_IDLE;
            ST_RECONF:     if (reconfig_ack) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register and deferred line event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            evt_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_RECONF && state_q != ST_RECONF)
                evt_pend_q <= 1'b0;
            else if (line_up_evt)
                evt_pend_q <= 1'b1;
        end
    end

    // Reported status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_up         <= 1'b0;
            speed_valid     <= 1'b0;
            speed_mbps      <= '0;
            full_duplex     <= 1'b0;
            partner_ability <= '0;
        end else begin
            unique case (state_q)
                ST_SAMPLE: begin
                    if (!rx_link_raw) begin
                        link_up     <= 1'b0;
                        speed_valid <= 1'b0;
                        speed_mbps  <= '0;
                        full_duplex <= 1'b0;
                    end else if (!an_enable) begin
                        link_up     <= 1'b1;
                        speed_valid <= fix_rate.valid;
                        speed_mbps  <= fix_rate.mbps;
                        full_duplex <= fix_rate.valid;
                    end
                end
                ST_CAPTURE: begin
                    link_up         <= 1'b1;
                    partner_ability <= partner_word;
                    speed_valid     <= neg_rate.valid;
                    speed_mbps      <= neg_rate.mbps;
                    full_duplex     <= neg_duplex;
                end
                default: ;
            endcase
        end
    end

    assign status_refresh = (state_q == ST_REFRESH_HI);
    assign latch_strobe   = (state_q == ST_LATCH_HI);
    assign reconfig_req   = (state_q == ST_RECONF);
endmodule

// File: rtl/link_watch_chk.sv
`timescale 1ns/1ps
module link_watch_chk #(
    parameter int SETTLE_CYC = 204
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reconfig_ack,
    input logic        status_refresh,
    input logic        latch_strobe,
    input logic        reconfig_req,
    input logic        link_up,
    input logic        speed_valid,
    input logic [13:0] speed_mbps,
    input logic        full_duplex
);
    localparam int RUN_W = $clog2(SETTLE_CYC + 2) + 1;

    logic [RUN_W-1:0] ref_run, lat_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_run <= '0;
            lat_run <= '0;
        end else begin
            ref_run <= status_refresh ? ref_run + 1'b1 : '0;
            lat_run <= latch_strobe   ? lat_run + 1'b1 : '0;
        end
    end

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({status_refresh, latch_strobe, reconfig_req}) <= 1);

    p_refresh_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_refresh) |-> ref_run == RUN_W'(SETTLE_CYC));

    p_latch_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_strobe) |-> lat_run == RUN_W'(SETTLE_CYC));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig_req && !reconfig_ack |=> reconfig_req);

    p_down_nospeed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |-> !speed_valid && !full_duplex);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_refresh || latch_strobe) |=>
            $stable({link_up, speed_valid, speed_mbps, full_duplex}));
endmodule

bind link_watch link_watch_chk #(.SETTLE_CYC(SETTLE_CYC)) u_link_watch_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reconfig_ack   (reconfig_ack),
    .status_refresh (status_refresh),
    .latch_strobe   (latch_strobe),
    .reconfig_req   (reconfig_req),
    .link_up        (link_up),
    .speed_valid    (speed_valid),
    .speed_mbps     (speed_mbps),
    .full_duplex    (full_duplex)
);

// File: tb/test_link_watch.sv
`timescale 1ns/1ps
module test_link_watch;
    localparam int S    = 204;
    localparam int WAIT = 4 * S + 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_tick = 1'b0, line_up_evt = 1'b0, rx_link_raw = 1'b0;
    logic        an_enable = 1'b0, reconfig_ack = 1'b0;
    logic [2:0]  spd_code = '0, adapt_code = '0;
    logic [15:0] partner_word = '0;
    logic        status_refresh, latch_strobe, reconfig_req, link_up;
    logic        speed_valid, full_duplex;
    logic [13:0] speed_mbps;
    logic [15:0] partner_ability;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    link_watch #(.SETTLE_CYC(S), .WORD_W(16)) i_link_watch (
        .clk(clk), .rst_n(rst_n), .poll_tick(poll_tick), .line_up_evt(line_up_evt),
        .rx_link_raw(rx_link_raw), .an_enable(an_enable), .spd_code(spd_code),
        .adapt_code(adapt_code), .partner_word(partner_word),
        .reconfig_ack(reconfig_ack), .status_refresh(status_refresh),
        .latch_strobe(latch_strobe), .reconfig_req(reconfig_req), .link_up(link_up),
        .speed_valid(speed_valid), .speed_mbps(speed_mbps), .full_duplex(full_duplex),
        .partner_ability(partner_ability)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_fixed(input int s, input int a);
        int b, d;
        case (s) 0: b = 10000; 1: b = 5000; 3: b = 2500; default: b = -1; endcase
        case (a) 0: d = 1; 1: d = 2; 2: d = 4; 3: d = 10; 4: d = 100;
                 5: d = 5; 6: d = 50; default: d = -1; endcase
        if (b < 0 || d < 0) return -1;
        return b / d;
    endfunction

    function automatic int exp_an(input int c);
        case (c) 0: return 10; 1: return 100; 2: return 1000;
                 3: return 10000; 4: return 2500; 5: return 5000;
                 default: return -1; endcase
    endfunction

    task automatic do_poll(output int hr, output int hl, output int gap, output int both);
        logic link0;
        bit   fell, changed;
        link0 = link_up; hr = 0; hl = 0; gap = 0; both = 0; fell = 0; changed = 0;
        @(negedge clk) poll_tick = 1'b1;
        @(negedge clk) poll_tick = 1'b0;
        for (int i = 0; i < WAIT; i++) begin
            if (status_refresh) hr++;
            if (latch_strobe) hl++;
            if ($countones({status_refresh, latch_strobe, reconfig_req}) > 1) both++;
            if (hr > 0 && !status_refresh) fell = 1;
            if (link_up != link0) changed = 1;
            if (fell && !changed) gap++;
            @(negedge clk);
        end
    endtask

    task automatic ack_req();
        @(negedge clk) reconfig_ack = 1'b1;
        @(negedge clk) reconfig_ack = 1'b0;
        @(negedge clk);
        check("R3 req released after ack", reconfig_req, 0);
    endtask

    task automatic t_reset();
        check("R1 link_up", link_up, 0);
        check("R1 speed_valid", speed_valid, 0);
        check("R1 duplex", full_duplex, 0);
        check("R1 strobes", {status_refresh, latch_strobe, reconfig_req}, 0);
    endtask

    task automatic t_link_down();
        int hr, hl, gap, both;
        rx_link_raw = 1'b0;
        for (int k = 0; k < 2; k++) begin
            do_poll(hr, hl, gap, both);
            check("R2 refresh width", hr, S);
            check("R3 req after down", reconfig_req, 1);
            check("R3 link down", link_up, 0);
            check("R3 no speed", speed_valid, 0);
            check("R10 exclusive", both, 0);
            ack_req();
        end
    endtask

    task automatic t_fixed_first();
        int hr, hl, gap, both;
        rx_link_raw = 1'b1; an_enable = 1'b0; spd_code = 3'd0; adapt_code = 3'd0;
        do_poll(hr, hl, gap, both);
        check("R2 settle gap", gap, S + 1);
        check("R5 link up", link_up, 1);
        check("R5 speed 10000", speed_mbps, 10000);
        check("R7 full duplex", full_duplex, 1);
        check("R4 no latch in fixed mode", hl, 0);
        check("R3 no req when up", reconfig_req, 0);
    endtask

    task automatic t_fixed_sweep();
        int hr, hl, gap, both, e;
        rx_link_raw = 1'b1; an_enable = 1'b0;
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 8; a++) begin
                spd_code = 3'(s); adapt_code = 3'(a);
                do_poll(hr, hl, gap, both);
                e = exp_fixed(s, a);
                check("R5 R6 valid", speed_valid, (e >= 0) ? 1 : 0);
                if (e >= 0) check("R6 speed", speed_mbps, e);
                check("R7 duplex", full_duplex, (e >= 0) ? 1 : 0);
                check("R7 link stays up", link_up, 1);
            end
        end
    endtask

    task automatic t_an();
        int hr, hl, gap, both, e;
        rx_link_raw = 1'b1; an_enable = 1'b1;
        for (int c = 0; c < 8; c++) begin
            partner_word = 16'h8000 | 16'(c << 9) | ((c % 2) ? 16'h1000 : 16'h0) | 16'h0021;
            do_poll(hr, hl, gap, both);
            e = exp_an(c);
            check("R4 latch width", hl, S);
            check("R4 captured word", partner_ability, partner_word);
            check("R4 valid", speed_valid, (e >= 0) ? 1 : 0);
            if (e >= 0) check("R4 speed", speed_mbps, e);
            check("R4 duplex bit", full_duplex, c % 2);
            check("R10 exclusive", both, 0);
        end
        an_enable = 1'b0;
    endtask

    task automatic t_evt_idle();
        @(negedge clk) line_up_evt = 1'b1;
        @(negedge clk) line_up_evt = 1'b0;
        check("R8 req from idle event", reconfig_req, 1);
        ack_req();
    endtask

    task automatic t_evt_during_poll();
        rx_link_raw = 1'b1; an_enable = 1'b0; spd_code = 3'd1; adapt_code = 3'd0;
        @(negedge clk) poll_tick = 1'b1;
        @(negedge clk) poll_tick = 1'b0;
        repeat (S / 2) @(negedge clk);
        line_up_evt = 1'b1;
        @(negedge clk) line_up_evt = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 deferred during poll", reconfig_req, 0);
        repeat (2 * S) @(negedge clk);
        check("R8 poll result kept", speed_mbps, 5000);
        check("R8 req after poll", reconfig_req, 1);
        ack_req();
    endtask

    task automatic t_tick_drop();
        int busy = 0;
        logic prev_link;
        rx_link_raw = 1'b1; an_enable = 1'b0; spd_code = 3'd0; adapt_code = 3'd0;
        @(negedge clk) poll_tick = 1'b1;
        @(negedge clk) poll_tick = 1'b0;
        repeat (S / 2) @(negedge clk);
        prev_link = link_up;
        rx_link_raw = 1'b0;
        poll_tick = 1'b1;
        @(negedge clk) poll_tick = 1'b0;
        check("R9 output held mid-poll", link_up, prev_link);
        repeat (2 * S) @(negedge clk);
        check("R3 down seen", reconfig_req, 1);
        poll_tick = 1'b1;
        @(negedge clk) poll_tick = 1'b0;
        ack_req();
        for (int i = 0; i < 3 * S; i++) begin
            if (status_refresh) busy++;
            @(negedge clk);
        end
        check("R9 dropped ticks start nothing", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_link_down();
        t_fixed_first();
        t_fixed_sweep();
        t_an();
        t_evt_idle();
        t_evt_during_poll();
        t_tick_drop();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule